// File: doc/BRIEF.md
# Binary Clock Timer with Tap Interrupts

This block counts a 256 Hz timing tick in an 8-bit binary counter. Each counter bit is a square wave at half the rate of the bit below it: bit 0 runs at 128 Hz and bit 7 at 1 Hz. Four of these bits serve as interrupt taps: 32 Hz, 8 Hz, 2 Hz and 1 Hz. When a tap goes from 1 to 0, the block sets a sticky flag for that tap. Software clears a flag by writing a 1 to it. A per-tap enable decides which flags drive the single combined interrupt line.

Software reaches the block over a small byte-wide register bus with four registers. The control register holds a run bit and a self-clearing counter-clear bit. The counter register can only be read. The enable register and the flag register share one bit layout. The counter can advance between two bus reads, so software reads it twice and keeps the value only when both reads agree. Read data is registered, and the interrupt output is registered.

Top module: `bin_clk_timer`

## Requirements
- R1: While run is 1, each cycle with `tick_i` high advances the counter by one and wraps from 0xFF to 0x00. Counter bit i toggles at 128/2^i Hz of a 256 Hz tick.
- R2: While run is 0, ticks are ignored and the counter holds its value.
- R3: The counter register (offset 1) resets to 0x00, can only be read, and ignores writes.
- R4: The enable register (offset 2) resets to 0x00 and maps bit 0 to 1 Hz (counter bit 7), bit 1 to 2 Hz (counter bit 6), bit 2 to 8 Hz (counter bit 4) and bit 3 to 32 Hz (counter bit 2). Its bits 7:4 always read 0.
- R5: A flag in the flag register (offset 3, same bit mapping as R4) sets when its counter bit falls from 1 to 0 on a tick, whatever its enable. Over 256 ticks from 0x00, the 1 Hz flag sets once, on the 256th tick.
- R6: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If a falling edge and a clear of the same flag happen in one cycle, the flag ends up set.
- R7: The flag register resets to 0x00, and its bits 7:4 always read 0.
- R8: In the control register (offset 0), bit 0 is run (read/write, reset 0). Writing 1 to bit 1 sets the counter to 0x00 on that clock edge, reads back as 0, and neither sets nor clears any flag.
- R9: `irq_o` is high exactly one cycle after any flag is set together with its enable bit, and is 0 after reset.
- R10: For a read (`bus_sel_i` high, `bus_we_i` low), `bus_rdata_o` carries the register value one cycle later. In other cycles it is 0. Addresses are BASE_ADDR plus the offset; 0x5000 is the default base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse at the 256 Hz base rate |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Combined registered interrupt request |

## Verification
The assertions assume that `tick_i` is a single-cycle pulse sampled on the rising edge, and that each bus access is one cycle long. They also assume reset is held for at least two cycles, so that every comparison against past values starts from reset state. The bench changes inputs only on falling edges and always drops the tick and the strobe after one cycle. It does put a tick and a flag-clear write into the same cycle on purpose, to reach the case where set and clear meet.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int CT_NTAP = 4;
  localparam int CT_DATA_W = 8;

  // flag/enable bit k watches counter bit CT_TAP_BIT[k]
  localparam int CT_TAP_BIT [CT_NTAP] = '{7, 6, 4, 2};

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_COUNT  = 2'd1,
    REG_IRQEN  = 2'd2,
    REG_IRQFLG = 2'd3
  } ct_reg_e;
endpackage

// File: rtl/ct_tap_counter.sv
module ct_tap_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] fall_o
);
  logic             step;
  logic [CNT_W-1:0] carry;
  logic [CNT_W-1:0] cnt_q;

  assign step = tick_i & run_i & ~clr_i;

  // ripple carry chain: bit i falls when bits i..0 are all ones on a step
  assign carry[0] = cnt_q[0];
  generate
    for (genvar i = 1; i < CNT_W; i++) begin : g_carry
      assign carry[i] = carry[i-1] & cnt_q[i];
    end
    for (genvar i = 0; i < CNT_W; i++) begin : g_fall
      assign fall_o[i] = step & carry[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ct_irq_flags.sv
module ct_irq_flags
  import ct_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int NTAP  = CT_NTAP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] fall_i,
  input  logic [NTAP-1:0]  clr_i,
  input  logic [NTAP-1:0]  en_i,
  output logic [NTAP-1:0]  flags_o,
  output logic [NTAP-1:0]  tap_fall_o,
  output logic             irq_o
);
  logic [NTAP-1:0] flags_q;
  logic [NTAP-1:0] flags_d;
  logic            irq_q;
  logic            unused_fall;

  generate
    for (genvar k = 0; k < NTAP; k++) begin : g_tap
      assign tap_fall_o[k] = fall_i[CT_TAP_BIT[k]];
    end
  endgenerate

  assign unused_fall = ^fall_i;

  // set has priority over write-1 clear
  assign flags_d = (flags_q & ~clr_i) | tap_fall_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq_q   <= |(flags_q & en_i);
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/ct_bus_regs.sv
module ct_bus_regs
  import ct_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h5000,
  parameter int              CNT_W     = 8,
  parameter int              NTAP      = CT_NTAP
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [CT_DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic [NTAP-1:0]      flags_i,
  output logic                 run_o,
  output logic                 cnt_clr_o,
  output logic [NTAP-1:0]      en_o,
  output logic [NTAP-1:0]      flag_clr_o,
  output logic [CT_DATA_W-1:0] rdata_o
);
  logic                 hit, wr, rd;
  ct_reg_e              idx;
  logic                 run_q;
  logic [NTAP-1:0]      en_q;
  logic [CT_DATA_W-1:0] rmux;
  logic [CT_DATA_W-1:0] rdata_q;
  logic                 unused_wdata_hi;

  assign hit = sel_i && (addr_i[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);
  assign idx = ct_reg_e'(addr_i[1:0]);
  assign wr  = hit && we_i;
  assign rd  = hit && !we_i;

  assign unused_wdata_hi = ^wdata_i[CT_DATA_W-1:NTAP];

  assign cnt_clr_o  = wr && (idx == REG_CTRL) && wdata_i[1];
  assign flag_clr_o = (wr && (idx == REG_IRQFLG)) ? wdata_i[NTAP-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      en_q  <= '0;
    end else if (wr) begin
      if (idx == REG_CTRL)  run_q <= wdata_i[0];
      if (idx == REG_IRQEN) en_q  <= wdata_i[NTAP-1:0];
    end
  end

  always_comb begin
    rmux = '0;
    unique case (idx)
      REG_CTRL:   rmux[0]          = run_q;
      REG_COUNT:  rmux[CNT_W-1:0]  = cnt_i;
      REG_IRQEN:  rmux[NTAP-1:0]   = en_q;
      REG_IRQFLG: rmux[NTAP-1:0]   = flags_i;
      default:    rmux             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= rmux;
    else         rdata_q <= '0;
  end

  assign run_o   = run_q;
  assign en_o    = en_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/bin_clk_timer.sv
module bin_clk_timer
  import ct_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h5000,
  parameter int                CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              irq_o
);
  localparam int NTAP = CT_NTAP;

  logic             run;
  logic             cnt_clr;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] fall_all;
  logic [NTAP-1:0]  tap_fall;
  logic [NTAP-1:0]  flags;
  logic [NTAP-1:0]  en;
  logic [NTAP-1:0]  flag_clr;

  ct_tap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_i),
    .run_i  (run),
    .clr_i  (cnt_clr),
    .cnt_o  (cnt),
    .fall_o (fall_all)
  );

  ct_irq_flags #(.CNT_W(CNT_W), .NTAP(NTAP)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .fall_i     (fall_all),
    .clr_i      (flag_clr),
    .en_i       (en),
    .flags_o    (flags),
    .tap_fall_o (tap_fall),
    .irq_o      (irq_o)
  );

  ct_bus_regs #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .CNT_W(CNT_W), .NTAP(NTAP)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .sel_i      (bus_sel_i),
    .we_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .cnt_i      (cnt),
    .flags_i    (flags),
    .run_o      (run),
    .cnt_clr_o  (cnt_clr),
    .en_o       (en),
    .flag_clr_o (flag_clr),
    .rdata_o    (bus_rdata_o)
  );
endmodule

// File: rtl/ct_checker.sv
module ct_checker #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h5000,
  parameter int                CNT_W     = 8,
  parameter int                NTAP      = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_i,
  input logic              run,
  input logic              cnt_clr,
  input logic [CNT_W-1:0]  cnt,
  input logic [NTAP-1:0]   tap_fall,
  input logic [NTAP-1:0]   flags,
  input logic [NTAP-1:0]   en,
  input logic [NTAP-1:0]   flag_clr,
  input logic              irq_o,
  input logic              bus_sel_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [7:0]        bus_rdata_o
);
  logic rd_mask_reg;
  assign rd_mask_reg = bus_sel_i && !bus_we_i &&
                       (bus_addr_i[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]) &&
                       bus_addr_i[1];

  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    (run && tick_i && !cnt_clr) |=> (cnt == $past(cnt) + 1'b1));

  p_gate_r2: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_clr) |=> $stable(cnt));

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (cnt == '0));

  p_set_r5: assert property (@(posedge clk) disable iff (rst)
    (|tap_fall) |=> ((flags & $past(tap_fall)) == $past(tap_fall)));

  p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
    (|(flag_clr & ~tap_fall)) |=> ((flags & $past(flag_clr & ~tap_fall)) == '0));

  p_irq_hi_r9: assert property (@(posedge clk) disable iff (rst)
    (|(flags & en)) |=> irq_o);

  p_irq_lo_r9: assert property (@(posedge clk) disable iff (rst)
    !(|(flags & en)) |=> !irq_o);

  p_rsvd_r7: assert property (@(posedge clk) disable iff (rst)
    rd_mask_reg |=> (bus_rdata_o[7:4] == 4'h0));
endmodule

bind bin_clk_timer ct_checker #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .CNT_W(CNT_W), .NTAP(NTAP)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick_i      (tick_i),
  .run         (run),
  .cnt_clr     (cnt_clr),
  .cnt         (cnt),
  .tap_fall    (tap_fall),
  .flags       (flags),
  .en          (en),
  .flag_clr    (flag_clr),
  .irq_o       (irq_o),
  .bus_sel_i   (bus_sel_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o)
);

// File: tb/tb_bin_clk_timer.sv
`timescale 1ns/1ps
module tb_bin_clk_timer;
  localparam logic [15:0] A_CTRL = 16'h5000;
  localparam logic [15:0] A_CNT  = 16'h5001;
  localparam logic [15:0] A_EN   = 16'h5002;
  localparam logic [15:0] A_FLG  = 16'h5003;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        sel = 1'b0;
  logic        we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bin_clk_timer dut (
    .clk(clk), .rst(rst), .tick_i(tick), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; we = 0; addr = a;
    @(negedge clk); sel = 0; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic restart_counter();
    bus_wr(A_CTRL, 8'h03);
    bus_wr(A_FLG, 8'h0F);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R10 rdata after reset", rdata, 8'h00);
    chk("R9 irq after reset", {7'b0, irq}, 8'h00);
    bus_rd(A_CTRL, v); chk("R8 ctrl reset", v, 8'h00);
    bus_rd(A_CNT, v);  chk("R3 count reset", v, 8'h00);
    bus_rd(A_EN, v);   chk("R4 enable reset", v, 8'h00);
    bus_rd(A_FLG, v);  chk("R7 flag reset", v, 8'h00);
    @(negedge clk);    chk("R10 rdata idle is zero", rdata, 8'h00);
  endtask

  task automatic t_run_gate();
    logic [7:0] v;
    ticks(5);
    bus_rd(A_CNT, v); chk("R2 ticks ignored while stopped", v, 8'h00);
  endtask

  task automatic t_count();
    logic [7:0] v;
    bus_wr(A_CTRL, 8'h01);
    ticks(5);
    bus_rd(A_CNT, v); chk("R1 five ticks", v, 8'h05);
    bus_wr(A_CNT, 8'hAA);
    bus_rd(A_CNT, v); chk("R3 count write ignored", v, 8'h05);
    bus_wr(A_CTRL, 8'h00);
    ticks(3);
    bus_rd(A_CNT, v); chk("R2 hold after stop", v, 8'h05);
    bus_wr(A_CTRL, 8'h01);
    ticks(2);
    bus_rd(A_CNT, v); chk("R1 resume", v, 8'h07);
  endtask

  task automatic t_taps();
    logic [7:0] v;
    restart_counter();
    bus_rd(A_CTRL, v); chk("R8 clear bit reads zero", v, 8'h01);
    bus_rd(A_CNT, v);  chk("R8 counter cleared", v, 8'h00);
    ticks(8);
    bus_rd(A_FLG, v);  chk("R5 32Hz flag after 8 ticks", v, 8'h08);
    ticks(247);
    bus_rd(A_FLG, v);  chk("R5 1Hz flag clear at 255 ticks", v & 8'h01, 8'h00);
    bus_rd(A_CNT, v);  chk("R1 count 0xFF", v, 8'hFF);
    ticks(1);
    bus_rd(A_FLG, v);  chk("R5 all flags after 256 ticks", v, 8'h0F);
    bus_rd(A_CNT, v);  chk("R1 wrap to zero", v, 8'h00);
    chk("R9 no irq while disabled", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_w1c();
    logic [7:0] v;
    bus_wr(A_FLG, 8'h05);
    bus_rd(A_FLG, v); chk("R6 write-1 clears bits 0 and 2", v, 8'h0A);
    bus_wr(A_FLG, 8'hF0);
    bus_rd(A_FLG, v); chk("R6 write-0 keeps flags", v, 8'h0A);
    bus_wr(A_CTRL, 8'h03);
    bus_rd(A_FLG, v); chk("R8 counter clear keeps flags", v, 8'h0A);
  endtask

  task automatic t_race();
    logic [7:0] v;
    restart_counter();
    ticks(7);
    bus_rd(A_FLG, v); chk("R6 no flags before race", v, 8'h00);
    @(negedge clk); tick = 1; sel = 1; we = 1; addr = A_FLG; wdata = 8'h08;
    @(negedge clk); tick = 0; sel = 0; we = 0;
    bus_rd(A_FLG, v); chk("R6 set wins over clear", v, 8'h08);
  endtask

  task automatic t_clear_no_set();
    logic [7:0] v;
    restart_counter();
    ticks(255);
    bus_wr(A_FLG, 8'h0F);
    bus_wr(A_CTRL, 8'h03);
    bus_rd(A_FLG, v); chk("R8 clear from 0xFF sets no flag", v, 8'h00);
    bus_rd(A_CNT, v); chk("R8 counter zero after clear", v, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    restart_counter();
    ticks(256);
    bus_wr(A_EN, 8'hFF);
    bus_rd(A_EN, v); chk("R4 enable reserved bits read zero", v, 8'h0F);
    chk("R9 irq with enabled flag", {7'b0, irq}, 8'h01);
    bus_wr(A_EN, 8'h00);
    @(negedge clk);
    chk("R9 irq off when disabled", {7'b0, irq}, 8'h00);
    bus_wr(A_EN, 8'h01);
    @(negedge clk);
    chk("R9 irq from 1Hz enable", {7'b0, irq}, 8'h01);
    bus_wr(A_FLG, 8'h01);
    @(negedge clk);
    chk("R9 irq drops after clear", {7'b0, irq}, 8'h00);
    bus_rd(A_FLG, v); chk("R7 flag reserved bits zero", v, 8'h0E);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_run_gate();
    t_count();
    t_taps();
    t_w1c();
    t_race();
    t_clear_no_set();
    t_irq();
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule